// File: doc/BRIEF.md
# Periodic Measurement Sequencer

This block schedules temperature conversions for a sensor front end. It derives a conversion-clock tick from the input clock through a programmable divider, holds off after enable until a programmable power-up delay has elapsed, and then issues conversion requests. Requests follow one of three measurement modes: one-shot, back-to-back, or paced by a period counter. The length of each conversion depends on a two-bit resolution field, and each setting doubles the length of the one below it.

Software controls the block through a control word that holds an enable bit, single-cycle start and stop request bits, a mode field and a resolution field. A divider word and a power-up word set the tick rate and the power-up hold-off. The analog converter is replaced by an internal counter. When that counter reaches the selected length, the block raises a done strobe and presents the sample that the converter interface supplies in the completing cycle.

Top module: `meas_seq`

## Requirements
- R1: While reset is asserted, and immediately after it is released, `conv_req` and `conv_done` are 0 and `sample_out` is 0.
- R2: `ctrl_word` bit 31 is the enable, bit 30 a one-cycle start request and bit 29 a one-cycle stop request. A start request made while the enable is 0 has no effect, including after the enable is later set.
- R3: With mode field `ctrl_word[25:24]` = 0 (or the spare code 3), a start produces exactly one conversion, and the sequencer then idles.
- R4: With mode 1 (continuous), every completed conversion is followed by the next `conv_req` in the clock after the completing tick.
- R5: After the enable rises, no `conv_req` occurs until `pud_word[23:16]` ticks have passed. A start given together with the enable produces its request in the cycle in which that count is reached.
- R6: A stop request during a conversion lets that conversion finish with its done strobe and prevents any further request. A stop request while armed or waiting returns the sequencer to idle at once.
- R7: Clearing the enable aborts any conversion without a done strobe and restarts the power-up hold-off.
- R8: When `div_word` bit 31 is 1, a tick occurs every (`div_word[23:16]` + 1) clocks, counted from the rise of the enable. When that bit is 0, every clock is a tick.
- R9: Resolution field `ctrl_word[19:18]` = r sets the conversion length to CONV_BASE·2^r ticks. `conv_done` pulses for one clock, one clock after the clock that carries the last of those ticks following the request.
- R10: While `conv_done` is high, `sample_out` equals the `adc_data` value that was present in the completing cycle.
- R11: With mode 2 (periodic), successive requests are `period_len` ticks apart. If that interval has already passed when a conversion completes, the next request follows in the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 32 | Enable, start, stop, mode and resolution |
| div_word | input | 32 | Divider enable (bit 31) and divide value (bits 23:16) |
| pud_word | input | 32 | Power-up hold-off in ticks (bits 23:16) |
| period_len | input | PER_W | Periodic interval in ticks |
| adc_data | input | DATA_W | Sample from the converter interface |
| conv_req | output | 1 | One-cycle conversion request |
| conv_done | output | 1 | One-cycle completion strobe |
| sample_out | output | DATA_W | Sample captured at completion |

## Verification
The embedded properties take for granted that the divider word and the power-up word change only while the enable is 0. They also assume that the resolution field does not change while a conversion is running, because the tick spacing, the monotonic power-up ready flag and the conversion count rely on those settings being stable. The stimulus writes these configuration words only during phases in which the enable is low, and it changes the mode and resolution only together with a start from idle. Start and stop bits are always driven as single-cycle pulses.

// File: rtl/meas_seq_pkg.sv
package meas_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_CONV,
    ST_WAIT
  } seq_state_e;

  localparam logic [1:0] MODE_SINGLE = 2'd0;
  localparam logic [1:0] MODE_CONT   = 2'd1;
  localparam logic [1:0] MODE_PER    = 2'd2;

  localparam int FIELD_W = 8;

  // Conversion length in ticks: base doubled per resolution step.
  function automatic int unsigned conv_cycles(int unsigned base, logic [1:0] res);
    return base << res;
  endfunction

  // Period has elapsed once the tick count since launch reaches period-1.
  function automatic logic period_due(int unsigned elapsed, int unsigned period);
    return (elapsed + 1) >= period;
  endfunction

endpackage

// File: rtl/meas_clkdiv.sv
module meas_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             div_en,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] dcnt;
  logic [DIV_W-1:0] dlim;

  assign dlim = div_en ? div_val : '0;
  assign tick = run && (dcnt >= dlim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             dcnt <= '0;
    else if (!run || tick)  dcnt <= '0;
    else                    dcnt <= dcnt + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dlim != '0) |=> !tick); // R8

endmodule

// File: rtl/meas_pud.sv
module meas_pud #(
  parameter int PUD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [PUD_W-1:0] pud_len,
  output logic             ready
);
  logic [PUD_W-1:0] pcnt;

  assign ready = run && (pcnt >= pud_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pcnt <= '0;
    else if (!run)           pcnt <= '0;
    else if (tick && !ready) pcnt <= pcnt + 1'b1;
  end

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && run) |=> (ready || !run)); // R5

endmodule

// File: rtl/meas_conv_stub.sv
module meas_conv_stub
  import meas_seq_pkg::*;
#(
  parameter int BASE  = 8,
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       tick,
  input  logic [1:0] res,
  output logic       done
);
  localparam int LW = CNT_W + 1;

  logic [CNT_W-1:0] ccnt;
  logic [LW-1:0]    len_m1;

  assign len_m1 = LW'(conv_cycles(BASE, res) - 1);
  assign done   = active && tick && ({1'b0, ccnt} == len_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ccnt <= '0;
    else if (!active) ccnt <= '0;
    else if (tick)    ccnt <= ccnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ({1'b0, ccnt} <= len_m1)); // R9

endmodule

// File: rtl/meas_seq.sv
module meas_seq
  import meas_seq_pkg::*;
#(
  parameter int CONV_BASE = 8,
  parameter int PER_W     = 24,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       ctrl_word,
  input  logic [31:0]       div_word,
  input  logic [31:0]       pud_word,
  input  logic [PER_W-1:0]  period_len,
  input  logic [DATA_W-1:0] adc_data,
  output logic              conv_req,
  output logic              conv_done,
  output logic [DATA_W-1:0] sample_out
);
  localparam int CNT_W = $clog2(CONV_BASE) + 4;

  // Field decode
  logic         en, start_req, stop_req;
  logic [1:0]   mode, res;
  logic         div_en;
  logic [FIELD_W-1:0] div_val, pud_len;
  logic         unused_bits;

  assign en        = ctrl_word[31];
  assign start_req = ctrl_word[30];
  assign stop_req  = ctrl_word[29];
  assign mode      = ctrl_word[25:24];
  assign res       = ctrl_word[19:18];
  assign div_en    = div_word[31];
  assign div_val   = div_word[23:16];
  assign pud_len   = pud_word[23:16];
  assign unused_bits = ^{ctrl_word[28:26], ctrl_word[23:20], ctrl_word[17:0],
                         div_word[30:24], div_word[15:0],
                         pud_word[31:24], pud_word[15:0]};

  // Named internal events
  logic             tick;
  logic             pud_ready;
  logic             conv_done_w;
  logic             conv_active;
  logic             due;
  logic             launch;

  seq_state_e       state;
  logic             stop_pend;
  logic [PER_W-1:0] perc;
  logic             done_q;
  logic [DATA_W-1:0] sample_q;

  meas_clkdiv #(.DIV_W(FIELD_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(en),
    .div_en(div_en), .div_val(div_val), .tick(tick)
  );

  meas_pud #(.PUD_W(FIELD_W)) u_pud (
    .clk(clk), .rst_n(rst_n), .run(en), .tick(tick),
    .pud_len(pud_len), .ready(pud_ready)
  );

  assign conv_active = en && (state == ST_CONV);

  meas_conv_stub #(.BASE(CONV_BASE), .CNT_W(CNT_W)) u_conv (
    .clk(clk), .rst_n(rst_n), .active(conv_active), .tick(tick),
    .res(res), .done(conv_done_w)
  );

  assign due    = period_due(32'(perc), 32'(period_len));
  assign launch = en && pud_ready &&
                  ((state == ST_ARM) || (state == ST_WAIT && due));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      stop_pend <= 1'b0;
      perc      <= '0;
      done_q    <= 1'b0;
      sample_q  <= '0;
    end else begin
      done_q <= conv_done_w;
      if (conv_done_w) sample_q <= adc_data;

      if (launch)                  perc <= '0;
      else if (tick && perc != '1) perc <= perc + 1'b1;

      if (!en) begin
        state     <= ST_IDLE;
        stop_pend <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: if (start_req && !stop_req) state <= ST_ARM;
          ST_ARM: begin
            if (stop_req)    state <= ST_IDLE;
            else if (launch) state <= ST_CONV;
          end
          ST_CONV: begin
            if (conv_done_w) begin
              stop_pend <= 1'b0;
              if (stop_pend || stop_req) state <= ST_IDLE;
              else if (mode == MODE_CONT) state <= ST_ARM;
              else if (mode == MODE_PER)  state <= due ? ST_ARM : ST_WAIT;
              else                        state <= ST_IDLE;
            end else if (stop_req) begin
              stop_pend <= 1'b1;
            end
          end
          ST_WAIT: begin
            if (stop_req)    state <= ST_IDLE;
            else if (launch) state <= ST_CONV;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign conv_req   = launch;
  assign conv_done  = done_q;
  assign sample_out = sample_q;

  AST_REQ_ENTERS_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> (state == ST_CONV)); // R4
  AST_SINGLE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done_w && (mode == MODE_SINGLE)) |=> (state == ST_IDLE)); // R3
  AST_STOP_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done_w && stop_pend) |=> !conv_req); // R6
  AST_OFF_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |=> (state == ST_IDLE && !conv_done)); // R7
  AST_SAMPLE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done_w |=> (conv_done && sample_out == $past(adc_data))); // R10

endmodule

// File: tb/meas_seq_tb.sv
module meas_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic [31:0] div_word = '0;
  logic [31:0] pud_word = '0;
  logic [23:0] period_len = '0;
  logic [15:0] adc_data = '0;
  logic        conv_req, conv_done;
  logic [15:0] sample_out;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  string tag = "R1";

  int          exp_req[$];
  int          exp_done_cyc[$];
  logic [15:0] exp_done_dat[$];

  meas_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .div_word(div_word),
    .pud_word(pud_word), .period_len(period_len), .adc_data(adc_data),
    .conv_req(conv_req), .conv_done(conv_done), .sample_out(sample_out)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] adc_val(int n);
    return 16'(n * 37 + 5);
  endfunction

  always @(negedge clk) adc_data = adc_val(cyc);

  function automatic logic [31:0] mk_ctrl(bit e, bit s, bit p, logic [1:0] m, logic [1:0] r);
    return {e, s, p, 3'b000, m, 4'b0000, r, 18'd0};
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic wait_to(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic push_conv(int req_cyc, int len);
    exp_req.push_back(req_cyc);
    exp_done_cyc.push_back(req_cyc + len + 1);
    exp_done_dat.push_back(adc_val(req_cyc + len));
  endtask

  task automatic end_phase();
    chk(exp_req.size() == 0, "pending requests", exp_req.size(), 0);
    chk(exp_done_cyc.size() == 0, "pending done strobes", exp_done_cyc.size(), 0);
    exp_req.delete();
    exp_done_cyc.delete();
    exp_done_dat.delete();
  endtask

  // Monitor: compares design events against the scoreboard queues
  always @(negedge clk) begin
    #3;
    if (rst_n && !finished) begin
      if (conv_req) begin
        if (exp_req.size() == 0) chk(1'b0, "unexpected conv_req", cyc, -1);
        else begin
          int e;
          e = exp_req.pop_front();
          chk(cyc == e, "conv_req cycle", cyc, e);
        end
      end
      if (conv_done) begin
        if (exp_done_cyc.size() == 0) chk(1'b0, "unexpected conv_done", cyc, -1);
        else begin
          int e;
          logic [15:0] d;
          e = exp_done_cyc.pop_front();
          d = exp_done_dat.pop_front();
          chk(cyc == e, "conv_done cycle", cyc, e);
          chk(sample_out == d, "sample_out R10", int'(sample_out), int'(d));
        end
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int c;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(conv_req == 1'b0, "R1 conv_req in reset", int'(conv_req), 0);
    chk(conv_done == 1'b0, "R1 conv_done in reset", int'(conv_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    chk(conv_req == 1'b0 && conv_done == 1'b0, "R1 outputs after reset", int'(conv_req), 0);
    chk(sample_out == 16'd0, "R1 sample_out after reset", int'(sample_out), 0);

    // R5 R3 R9 R10: enable with start, power-up of 20 ticks, single mode
    tag = "R5 R3 R9";
    @(negedge clk);
    c = cyc;
    pud_word  = {8'h00, 8'd20, 16'h0000};
    ctrl_word = mk_ctrl(1, 1, 0, 2'd0, 2'd0);
    push_conv(c + 20, 8);
    @(negedge clk);
    ctrl_word = mk_ctrl(1, 0, 0, 2'd0, 2'd0);
    wait_to(c + 70);
    end_phase();

    // R4 R6 R9: continuous, resolution 1 (16 ticks), stop during third conversion
    tag = "R4 R6 R9";
    c = cyc;
    ctrl_word = mk_ctrl(1, 1, 0, 2'd1, 2'd1);
    push_conv(c + 1, 16);
    push_conv(c + 18, 16);
    push_conv(c + 35, 16);
    @(negedge clk);
    ctrl_word = mk_ctrl(1, 0, 0, 2'd1, 2'd1);
    wait_to(c + 40);
    ctrl_word = mk_ctrl(1, 0, 1, 2'd1, 2'd1);
    @(negedge clk);
    ctrl_word = mk_ctrl(1, 0, 0, 2'd1, 2'd1);
    wait_to(c + 100);
    end_phase();

    // R11 R6: periodic, period 40 ticks, stop while waiting
    tag = "R11 R6";
    c = cyc;
    period_len = 24'd40;
    ctrl_word = mk_ctrl(1, 1, 0, 2'd2, 2'd0);
    push_conv(c + 1, 8);
    push_conv(c + 41, 8);
    push_conv(c + 81, 8);
    @(negedge clk);
    ctrl_word = mk_ctrl(1, 0, 0, 2'd2, 2'd0);
    wait_to(c + 101);
    ctrl_word = mk_ctrl(1, 0, 1, 2'd2, 2'd0);
    @(negedge clk);
    ctrl_word = mk_ctrl(1, 0, 0, 2'd2, 2'd0);
    wait_to(c + 170);
    end_phase();

    // R11: period shorter than a conversion, next request right after completion
    tag = "R11 short period";
    c = cyc;
    period_len = 24'd3;
    ctrl_word = mk_ctrl(1, 1, 0, 2'd2, 2'd0);
    push_conv(c + 1, 8);
    push_conv(c + 10, 8);
    push_conv(c + 19, 8);
    @(negedge clk);
    ctrl_word = mk_ctrl(1, 0, 0, 2'd2, 2'd0);
    wait_to(c + 22);
    ctrl_word = mk_ctrl(1, 0, 1, 2'd2, 2'd0);
    @(negedge clk);
    ctrl_word = mk_ctrl(1, 0, 0, 2'd2, 2'd0);
    wait_to(c + 60);
    end_phase();

    // R2: start with enable low is ignored, even after enable rises
    tag = "R2";
    c = cyc;
    ctrl_word = mk_ctrl(0, 0, 0, 2'd0, 2'd0);
    wait_to(c + 2);
    ctrl_word = mk_ctrl(0, 1, 0, 2'd0, 2'd0);
    @(negedge clk);
    ctrl_word = mk_ctrl(0, 0, 0, 2'd0, 2'd0);
    wait_to(c + 5);
    ctrl_word = mk_ctrl(1, 0, 0, 2'd0, 2'd0);
    wait_to(c + 45);
    end_phase();

    // R7: dropping enable mid-conversion aborts with no done strobe
    tag = "R7";
    c = cyc;
    ctrl_word = mk_ctrl(1, 1, 0, 2'd0, 2'd2);
    exp_req.push_back(c + 1);
    @(negedge clk);
    ctrl_word = mk_ctrl(1, 0, 0, 2'd0, 2'd2);
    wait_to(c + 10);
    ctrl_word = '0;
    div_word  = {1'b1, 7'd0, 8'd3, 16'd0};
    pud_word  = {8'h00, 8'd2, 16'h0000};
    wait_to(c + 12);
    end_phase();

    // R8 R7 R5: divide by 4, power-up of 2 ticks restarts after re-enable
    tag = "R8 R7 R5";
    c = cyc;
    ctrl_word = mk_ctrl(1, 1, 0, 2'd0, 2'd0);
    exp_req.push_back(c + 8);
    exp_done_cyc.push_back(c + 40);
    exp_done_dat.push_back(adc_val(c + 39));
    @(negedge clk);
    ctrl_word = mk_ctrl(1, 0, 0, 2'd0, 2'd0);
    wait_to(c + 80);
    end_phase();

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule